// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns a single serial line into parallel characters. The line rests high. A falling edge begins a frame. The receiver then times each bit from its own clock, divided by a programmable oversampling factor, and takes a sample at the centre of every bit. A frame is one start bit, five to eight data bits sent least significant bit first, an optional parity bit and a stop bit.

Each finished character goes into a one-entry holding register, and a ready flag tells the host that a character is waiting. Parity, framing and overrun problems raise sticky flags. These flags never pause reception. The host clears the ready flag with a read strobe and clears the error flags with a separate clear strobe.

The mode inputs must stay constant while reception is enabled. To change them, first reset the block or drop the enable.

Top module: `serial_rx`

## Requirements
- R1: After reset, `ready_o`, `par_err_o`, `frm_err_o` and `ovr_err_o` are 0 and `data_o` is zero. An idle high line produces no character.
- R2: `rate_i` selects the clock divisor: 0 gives 1x, 1 gives 16x, 2 or 3 give 64x. Take edge 0 as the first rising clock edge that sees the line low after it was high. Bit k (start bit = 0) is sampled at edge F/2 + F*k, with integer division. `ready_o` rises one edge after the stop-bit sample.
- R3: In 16x and 64x modes the start bit is sampled again at edge F/2. If the line is high there, the frame is dropped with no character and no flag. In 1x mode the first low sample is accepted as the start bit.
- R4: `len_i` sets the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8. The first bit received lands in `data_o[0]`, and unused upper bits of `data_o` read as 0.
- R5: When `par_en_i` is 1, a parity bit follows the data. With `par_odd_i` = 0 the data plus parity must hold an even number of ones; with 1 it must hold an odd number. A mismatch sets `par_err_o`. The parity bit never appears in `data_o`.
- R6: A low stop-bit sample sets `frm_err_o`. The character is still stored and `ready_o` still rises.
- R7: Only one stop bit is checked. A new start bit may follow directly after it.
- R8: `ready_o` is set when a character is stored and cleared by a cycle with `rd_i` high. The stored data stays visible after the read.
- R9: If a character is stored while `ready_o` is still set, it replaces the old one and `ovr_err_o` is set.
- R10: Error flags stay set through later characters and reads. Only `err_clr_i` clears them, and it does not affect `ready_o` or `data_o`.
- R11: While `rx_en_i` is 0, the line is ignored and no character is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock; the line is sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_en_i | input | 1 | Receiver enable |
| rate_i | input | 2 | Divisor select (0: 1x, 1: 16x, 2/3: 64x) |
| len_i | input | 2 | Data length select (0..3 gives 5..8 bits) |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| rxd_i | input | 1 | Serial line |
| rd_i | input | 1 | Host read strobe, clears `ready_o` |
| err_clr_i | input | 1 | Clears all error flags |
| data_o | output | DATA_W | Received character, right-justified |
| ready_o | output | 1 | Character waiting |
| par_err_o | output | 1 | Sticky parity error |
| frm_err_o | output | 1 | Sticky framing error |
| ovr_err_o | output | 1 | Sticky overrun error |

## Verification
The bench uses the default parameters: 8-bit characters, a 16x middle divisor and a 64x upper divisor. The 1x mode has one clock per bit, so the exact edge at which `ready_o` rises can be checked, and back-to-back frames can run with no idle gap. At 16x, a four-cycle low pulse ends before the mid-bit resample, which exercises start-bit rejection. The 64x setting exercises the widest counter value and the 7-bit odd-parity path.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  localparam logic [1:0] RATE_X1  = 2'd0;
  localparam logic [1:0] RATE_X16 = 2'd1;
endpackage

// File: rtl/serial_rx_timer.sv
module serial_rx_timer #(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64,
  parameter int CNT_W   = $clog2(DIV_HI)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rate_i,
  input  logic       load_half_i,
  input  logic       load_full_i,
  output logic       tick_o,
  output logic       one_x_o
);
  import serial_rx_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] full_tab [4];
  logic [CNT_W-1:0] half_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_tab
    localparam int FAC = (g == 0) ? 1 : ((g == 1) ? DIV_MID : DIV_HI);
    assign full_tab[g] = CNT_W'(FAC - 1);
    assign half_tab[g] = CNT_W'((FAC / 2 == 0) ? 0 : FAC / 2 - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_half_i)      cnt_q <= half_tab[rate_i];
    else if (load_full_i)      cnt_q <= full_tab[rate_i];
    else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign tick_o  = (cnt_q == '0);
  assign one_x_o = (rate_i == RATE_X1);

  // R2
  one_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_half_i && load_full_i));

  // R3
  mid_resample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_half_i && rate_i != RATE_X1) |=> !tick_o);
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              rx_en_i,
  input  logic [1:0]        len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              tick_i,
  input  logic              one_x_i,
  output logic              load_half_o,
  output logic              load_full_o,
  output logic              done_o,
  output logic [DATA_W-1:0] char_o,
  output logic              perr_o,
  output logic              ferr_o
);
  import serial_rx_pkg::*;

  rx_state_e         state_q;
  logic              rxd_q;
  logic [DATA_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic              acc_q;
  logic              perr_q;
  logic [IDX_W-1:0]  last_idx;
  logic              fall;

  assign last_idx = IDX_W'(DATA_W - 4) + IDX_W'(len_i);
  assign fall     = rxd_q && !rxd_i;

  always_comb begin
    load_half_o = rx_en_i && (state_q == RX_IDLE) && fall;
    load_full_o = 1'b0;
    if (rx_en_i && tick_i) begin
      unique case (state_q)
        RX_START:        load_full_o = !rxd_i;
        RX_DATA, RX_PAR: load_full_o = 1'b1;
        default:         load_full_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      rxd_q   <= 1'b1;
      shreg_q <= '0;
      idx_q   <= '0;
      acc_q   <= 1'b0;
      perr_q  <= 1'b0;
      done_o  <= 1'b0;
      char_o  <= '0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      rxd_q  <= rxd_i;
      done_o <= 1'b0;
      if (!rx_en_i) begin
        state_q <= RX_IDLE;
      end else begin
        unique case (state_q)
          RX_IDLE: if (fall) begin
            shreg_q <= '0;
            idx_q   <= '0;
            acc_q   <= 1'b0;
            perr_q  <= 1'b0;
            state_q <= one_x_i ? RX_DATA : RX_START;
          end
          RX_START: if (tick_i) state_q <= rxd_i ? RX_IDLE : RX_DATA;
          RX_DATA: if (tick_i) begin
            shreg_q[idx_q] <= rxd_i;
            acc_q          <= acc_q ^ rxd_i;
            if (idx_q == last_idx) state_q <= par_en_i ? RX_PAR : RX_STOP;
            else                   idx_q   <= idx_q + IDX_W'(1);
          end
          RX_PAR: if (tick_i) begin
            perr_q  <= (acc_q ^ rxd_i) != par_odd_i;
            state_q <= RX_STOP;
          end
          RX_STOP: if (tick_i) begin
            done_o  <= 1'b1;
            char_o  <= shreg_q;
            perr_o  <= perr_q;
            ferr_o  <= !rxd_i;
            state_q <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  // R11
  en_off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (state_q == RX_IDLE) && !done_o);

  // R8
  done_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(state_q == RX_STOP && tick_i));
endmodule

// File: rtl/serial_rx_buf.sv
module serial_rx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] char_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  input  logic              rd_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              ovr_err_o
);
  logic ovr_set;
  assign ovr_set = load_i && ready_o && !rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      ready_o   <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      ovr_err_o <= 1'b0;
    end else begin
      if (load_i)    data_o <= char_i;
      if (load_i)    ready_o <= 1'b1;
      else if (rd_i) ready_o <= 1'b0;
      // set wins over clear
      if (load_i && perr_i) par_err_o <= 1'b1;
      else if (err_clr_i)   par_err_o <= 1'b0;
      if (load_i && ferr_i) frm_err_o <= 1'b1;
      else if (err_clr_i)   frm_err_o <= 1'b0;
      if (ovr_set)          ovr_err_o <= 1'b1;
      else if (err_clr_i)   ovr_err_o <= 1'b0;
    end
  end

  // R8
  ready_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(load_i));

  // R8
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !load_i) |=> !ready_o);

  // R9
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && ready_o && !rd_i) |=> ovr_err_o && ready_o);

  // R10
  par_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o && !err_clr_i) |=> par_err_o);

  // R10
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !load_i) |=> !par_err_o && !frm_err_o && !ovr_err_o);
endmodule

// File: rtl/serial_rx.sv
module serial_rx #(
  parameter int DATA_W  = 8,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic [1:0]        rate_i,
  input  logic [1:0]        len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rxd_i,
  input  logic              rd_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              ovr_err_o
);
  logic              tick, one_x, load_half, load_full;
  logic              done, perr, ferr;
  logic [DATA_W-1:0] char_w;

  serial_rx_timer #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rate_i      (rate_i),
    .load_half_i (load_half),
    .load_full_i (load_full),
    .tick_o      (tick),
    .one_x_o     (one_x)
  );

  serial_rx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rxd_i       (rxd_i),
    .rx_en_i     (rx_en_i),
    .len_i       (len_i),
    .par_en_i    (par_en_i),
    .par_odd_i   (par_odd_i),
    .tick_i      (tick),
    .one_x_i     (one_x),
    .load_half_o (load_half),
    .load_full_o (load_full),
    .done_o      (done),
    .char_o      (char_w),
    .perr_o      (perr),
    .ferr_o      (ferr)
  );

  serial_rx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (done),
    .char_i    (char_w),
    .perr_i    (perr),
    .ferr_i    (ferr),
    .rd_i      (rd_i),
    .err_clr_i (err_clr_i),
    .data_o    (data_o),
    .ready_o   (ready_o),
    .par_err_o (par_err_o),
    .frm_err_o (frm_err_o),
    .ovr_err_o (ovr_err_o)
  );
endmodule

// File: tb/serial_rx_bench.sv
module serial_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b1;
  logic [1:0] rate = 2'd0;
  logic [1:0] len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rxd = 1'b1;
  logic       rd = 1'b0;
  logic       err_clr = 1'b0;
  logic [7:0] data;
  logic       ready, par_err, frm_err, ovr_err;
  int         n_chk = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  serial_rx u_serial_rx (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .rate_i(rate), .len_i(len),
    .par_en_i(par_en), .par_odd_i(par_odd), .rxd_i(rxd), .rd_i(rd),
    .err_clr_i(err_clr), .data_o(data), .ready_o(ready), .par_err_o(par_err),
    .frm_err_o(frm_err), .ovr_err_o(ovr_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int fac();
    return (rate == 2'd0) ? 1 : ((rate == 2'd1) ? 16 : 64);
  endfunction

  function automatic logic [7:0] mask();
    return 8'((9'd1 << (5 + len)) - 9'd1);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; rxd = 1'b1; rd = 1'b0; err_clr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int f = fac();
    logic p = (^(d & mask())) ^ par_odd ^ bad_par;
    rxd = 1'b0;
    repeat (f) @(negedge clk);
    for (int i = 0; i < 5 + len; i++) begin
      rxd = d[i];
      repeat (f) @(negedge clk);
    end
    if (par_en) begin
      rxd = p;
      repeat (f) @(negedge clk);
    end
    rxd = !bad_stop;
    repeat (f) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic pulse_rd();
    rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    rate = 2'd1; len = 2'd3; par_en = 1'b0;
    do_reset();
    chk("R1 ready", ready, 0);
    chk("R1 flags", {par_err, frm_err, ovr_err}, 0);
    chk("R1 data", data, 0);
    repeat (50) @(negedge clk);
    chk("R1 idle line", ready, 0);
  endtask

  task automatic t_timing_1x();
    rate = 2'd0; len = 2'd3; par_en = 1'b0;
    do_reset();
    send_frame(8'hA5, 0, 0);
    chk("R2 not yet ready at stop edge", ready, 0);
    @(negedge clk);
    chk("R2 ready one edge after stop", ready, 1);
    chk("R4 data 1x", data, 8'hA5);
  endtask

  task automatic t_len5();
    rate = 2'd1; len = 2'd0; par_en = 1'b1; par_odd = 1'b0;
    do_reset();
    send_frame(8'hF3, 0, 0);
    repeat (2) @(negedge clk);
    chk("R4 5-bit right-justified", data, 8'h13);
    chk("R5 even parity ok", par_err, 0);
  endtask

  task automatic t_odd_64();
    rate = 2'd2; len = 2'd2; par_en = 1'b1; par_odd = 1'b1;
    do_reset();
    send_frame(8'hDA, 0, 0);
    repeat (2) @(negedge clk);
    chk("R2 64x data", data, 8'h5A);
    chk("R5 odd parity ok", par_err, 0);
  endtask

  task automatic t_parity_err();
    rate = 2'd1; len = 2'd3; par_en = 1'b1; par_odd = 1'b0;
    do_reset();
    send_frame(8'h81, 1, 0);
    repeat (2) @(negedge clk);
    chk("R5 parity error", par_err, 1);
    chk("R5 data without parity", data, 8'h81);
    pulse_rd();
    send_frame(8'h42, 0, 0);
    repeat (2) @(negedge clk);
    chk("R10 flag sticky", par_err, 1);
    chk("R10 reception continues", data, 8'h42);
    pulse_clr();
    chk("R10 cleared", {par_err, frm_err, ovr_err}, 0);
    chk("R10 ready kept", ready, 1);
    chk("R10 data kept", data, 8'h42);
  endtask

  task automatic t_frame_err();
    rate = 2'd1; len = 2'd3; par_en = 1'b0;
    do_reset();
    send_frame(8'h3C, 0, 1);
    repeat (2) @(negedge clk);
    chk("R6 framing error", frm_err, 1);
    chk("R6 ready", ready, 1);
    chk("R6 data", data, 8'h3C);
  endtask

  task automatic t_back2back();
    rate = 2'd0; len = 2'd3; par_en = 1'b0;
    do_reset();
    send_frame(8'h11, 0, 0);
    send_frame(8'hE7, 0, 0);
    repeat (2) @(negedge clk);
    chk("R7 second frame no gap", data, 8'hE7);
    chk("R9 overrun", ovr_err, 1);
    chk("R7 no framing error", frm_err, 0);
    pulse_rd();
    chk("R8 read clears ready", ready, 0);
    chk("R8 data kept after read", data, 8'hE7);
    chk("R10 overrun sticky", ovr_err, 1);
  endtask

  task automatic t_glitch();
    rate = 2'd1; len = 2'd3; par_en = 1'b0;
    do_reset();
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    chk("R3 short low rejected", ready, 0);
    chk("R3 no flags", {par_err, frm_err, ovr_err}, 0);
    send_frame(8'h96, 0, 0);
    repeat (2) @(negedge clk);
    chk("R3 clean frame after glitch", data, 8'h96);
  endtask

  task automatic t_disable();
    rate = 2'd1; len = 2'd3; par_en = 1'b0;
    do_reset();
    rx_en = 1'b0;
    send_frame(8'h55, 0, 0);
    repeat (4) @(negedge clk);
    chk("R11 disabled ignores line", ready, 0);
    rx_en = 1'b1;
    @(negedge clk);
    send_frame(8'h6B, 0, 0);
    repeat (2) @(negedge clk);
    chk("R11 enabled receives", data, 8'h6B);
  endtask

  initial begin
    t_reset();
    t_timing_1x();
    t_len5();
    t_odd_64();
    t_parity_err();
    t_frame_err();
    t_back2back();
    t_glitch();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule